// File: doc/BRIEF.md
# ADC Sample-Module Trigger Sequencer

This block is the trigger front end of a converter controller with thirteen sample slots. Each slot watches one hardware start source picked by its own 5-bit select code. The sources are an external start pin, two loop-back scan interrupts, four timer overflow pulses and twelve PWM event pulses. Each slot also has a software start bit that always works. Once a slot is triggered it waits a programmable delay: an 8-bit count of ticks from a prescaler that divides by 1, 2, 4 or 16. After the delay the slot becomes pending.

A single shared conversion engine serves the pending slots one at a time, lowest slot number first. The engine is modelled as a fixed 14-cycle busy window that ends in a one-cycle end-of-conversion pulse for the slot it served. Four interrupt channels each combine a per-slot mask over these end pulses. Each channel gives a pulse, a sticky flag that software clears by writing 1, and a request gated by an enable.

Interrupt channels 0 and 1 loop back as trigger sources. A slot that selects one of them, and that is itself in the mask of that channel, keeps rescanning with no software help until its select code is cleared.

Top module: `adc_trig_seq`

## Requirements
- R1: The 5-bit select code of each slot picks its hardware start source. Code 0 picks no source. Code 1 picks the external pin. Codes 2 and 3 pick interrupt pulse 0 and 1. Codes 4 to 7 pick timer overflow 0 to 3. Codes 8 to 19 pick PWM event 0 to 11. Codes 20 to 31 pick no source. A pulse on any source that is not selected has no effect.
- R2: A software start bit starts its slot whatever the select code is.
- R3: With delay count N and prescale code D, the prescale code maps 0, 1, 2, 3 to a divisor V of 1, 2, 4, 16. The slot becomes pending N*V clocks after the edge that samples the trigger. With no other activity, its end-of-conversion pulse is visible N*V+15 clocks after that edge. N=0 means no delay.
- R4: Pending slots are granted one per conversion in ascending slot order. Each grant comes one clock after the engine is idle with a pending slot. Three slots triggered together finish 15 clocks apart.
- R5: A conversion holds conv_busy high for exactly 14 clocks, with conv_mod showing the slot. It ends with a one-clock pulse on that slot's eoc bit. Only one eoc bit is high at a time.
- R6: A trigger to a slot that is delaying, pending or converting is ignored. The slot converts once.
- R7: Bit k of int_pulse pulses for one clock, one clock after an eoc pulse of any slot whose bit is set in mask k. Mask k is int_mask[k*13 +: 13], and its bit m enables slot m.
- R8: An int_pulse bit sets the matching int_flag bit, and the flag stays set. A stat_clr bit written high for one clock clears the flag. int_req is int_flag gated by int_en.
- R9: A slot that selects code 2 and is set in mask 0 rescans by itself once started. Its eoc pulses are 17 clocks apart. Clearing its select code to 0 stops the scan.
- R10: The external pin triggers only on a low-to-high change. Holding it high does not trigger again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low reset |
| mod_sel | input | 65 | Select code per slot, slot m at [m*5 +: 5] |
| dly_cnt | input | 104 | Delay count per slot, slot m at [m*8 +: 8] |
| dly_div | input | 26 | Prescale code per slot, slot m at [m*2 +: 2] |
| sw_trig | input | 13 | Software start, one bit per slot |
| ext_st | input | 1 | External start pin |
| tmr_ovf | input | 4 | Timer overflow pulses |
| pwm_evt | input | 12 | PWM event pulses |
| int_mask | input | 52 | Slot mask per interrupt channel |
| int_en | input | 4 | Request enable per channel |
| stat_clr | input | 4 | Write-1 clear of the channel flags |
| eoc | output | 13 | End-of-conversion pulse per slot |
| int_pulse | output | 4 | Interrupt pulse per channel |
| int_flag | output | 4 | Sticky status flag per channel |
| int_req | output | 4 | Enabled interrupt request |
| conv_busy | output | 1 | Engine busy |
| conv_mod | output | 4 | Slot being converted |

## Verification
Some checks hold on every cycle and the assertions cover them. They check that grants are one-hot and go to the lowest pending slot. They check that a grant reaches only a pending slot and that end pulses are one-hot and close a busy window. They check that a zero delay makes a slot pending at once, and that interrupt pulses set flags while a clear drops them.

Other properties only show up across whole scenarios, so the bench covers them. These include the exact clock counts of each delay and prescale pair, the spacing of queued conversions, and the 17-clock period of a self-sustained scan and its stop. They also include that every select code routes only its own source, and that retriggers and a held pin change nothing.

// File: rtl/adc_ts_pkg.sv
package adc_ts_pkg;

   typedef enum logic [1:0] {
      MS_IDLE = 2'd0,
      MS_WAIT = 2'd1,
      MS_PEND = 2'd2,
      MS_CONV = 2'd3
   } mod_state_e;

   // select codes whose position is part of the behaviour
   localparam int SRC_EXT      = 1;
   localparam int SRC_SCAN0    = 2;
   localparam int SRC_SCAN1    = 3;
   localparam int SRC_TMR_BASE = 4;

   // prescale code -> last tick index of the divider
   function automatic logic [3:0] tick_limit(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd0;
         2'd1:    return 4'd1;
         2'd2:    return 4'd3;
         default: return 4'd15;
      endcase
   endfunction

endpackage

// File: rtl/adc_ts_src_sel.sv
module adc_ts_src_sel
   import adc_ts_pkg::*;
#(
   parameter int SEL_W   = 5,
   parameter int NUM_TMR = 4,
   parameter int NUM_PWM = 12
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic               ext_hit,
   input  logic               scan0,
   input  logic               scan1,
   input  logic [NUM_TMR-1:0] tmr,
   input  logic [NUM_PWM-1:0] pwm,
   output logic               hw_trig
);

   localparam int PWM_BASE = SRC_TMR_BASE + NUM_TMR;
   localparam int USED     = PWM_BASE + NUM_PWM;
   localparam int NUM_CODE = 1 << SEL_W;

   initial assert (USED <= NUM_CODE)
      else $error("select field too narrow for the source list");

   logic [NUM_CODE-1:0] code_hit;

   always_comb begin
      code_hit                          = '0;
      code_hit[SRC_EXT]                 = ext_hit;
      code_hit[SRC_SCAN0]               = scan0;
      code_hit[SRC_SCAN1]               = scan1;
      code_hit[SRC_TMR_BASE +: NUM_TMR] = tmr;
      code_hit[PWM_BASE +: NUM_PWM]     = pwm;
   end

   assign hw_trig = code_hit[sel];

endmodule

// File: rtl/adc_ts_chan.sv
module adc_ts_chan
   import adc_ts_pkg::*;
#(
   parameter int DLY_W = 8,
   parameter int CUR_W = 4,
   parameter int IDX   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic [DLY_W-1:0] dly_cnt,
   input  logic [1:0]       dly_div,
   input  logic             gnt,
   input  logic             fin,
   input  logic [CUR_W-1:0] cur,
   output logic             pend
);

   localparam logic [CUR_W-1:0] MY_ID   = CUR_W'(IDX);
   localparam logic [DLY_W-1:0] ONE_LEFT = DLY_W'(1);

   mod_state_e       st;
   logic [DLY_W-1:0] rem;
   logic [3:0]       pre;
   logic [3:0]       lim;

   assign lim = tick_limit(dly_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= MS_IDLE;
         rem <= '0;
         pre <= '0;
      end else begin
         case (st)
            MS_IDLE: begin
               if (trig) begin
                  pre <= '0;
                  rem <= dly_cnt;
                  st  <= (dly_cnt == '0) ? MS_PEND : MS_WAIT;
               end
            end
            MS_WAIT: begin
               if (pre == lim) begin
                  pre <= '0;
                  rem <= rem - ONE_LEFT;
                  if (rem == ONE_LEFT) st <= MS_PEND;
               end else begin
                  pre <= pre + 4'd1;
               end
            end
            MS_PEND: begin
               if (gnt) st <= MS_CONV;
            end
            MS_CONV: begin
               if (fin && cur == MY_ID) st <= MS_IDLE;
            end
            default: st <= MS_IDLE;
         endcase
      end
   end

   assign pend = (st == MS_PEND);

   AST_ZERO_DELAY_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == MS_IDLE && trig && dly_cnt == '0) |=> pend); // R3
   AST_GRANT_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      gnt |-> st == MS_PEND); // R4
   AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !gnt) |=> pend); // R6

endmodule

// File: rtl/adc_ts_engine.sv
module adc_ts_engine #(
   parameter int NUM_MOD  = 13,
   parameter int CONV_CYC = 14,
   parameter int CUR_W    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_MOD-1:0] pend,
   output logic [NUM_MOD-1:0] gnt,
   output logic               fin,
   output logic [CUR_W-1:0]   cur,
   output logic               busy,
   output logic [NUM_MOD-1:0] eoc
);

   localparam int                 CNT_W = $clog2(CONV_CYC);
   localparam logic [CNT_W-1:0]   LAST  = CNT_W'(CONV_CYC - 1);
   localparam logic [NUM_MOD-1:0] LSB   = NUM_MOD'(1);

   initial assert (CONV_CYC >= 2) else $error("conversion length too short");
   initial assert (NUM_MOD <= (1 << CUR_W)) else $error("slot index too narrow");

   logic [CNT_W-1:0]   cnt;
   logic               found;
   logic [CUR_W-1:0]   pick;
   logic [NUM_MOD-1:0] eoc_nx;

   always_comb begin
      gnt   = '0;
      found = 1'b0;
      pick  = '0;
      for (int i = 0; i < NUM_MOD; i++) begin
         if (!busy && pend[i] && !found) begin
            gnt[i] = 1'b1;
            found  = 1'b1;
            pick   = CUR_W'(i);
         end
      end
   end

   assign fin = busy && (cnt == LAST);

   always_comb begin
      for (int i = 0; i < NUM_MOD; i++) eoc_nx[i] = fin && (cur == CUR_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         cur  <= '0;
         eoc  <= '0;
      end else begin
         eoc <= eoc_nx;
         if (found) begin
            busy <= 1'b1;
            cnt  <= '0;
            cur  <= pick;
         end else if (fin) begin
            busy <= 1'b0;
         end else if (busy) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R4
   AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt) |-> ((pend & (gnt - LSB)) == '0)); // R4
   AST_EOC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eoc)); // R5
   AST_EOC_CLOSES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (|eoc) |-> ($past(busy) && !busy)); // R5

endmodule

// File: rtl/adc_ts_irq.sv
module adc_ts_irq #(
   parameter int NUM_MOD = 13,
   parameter int NUM_INT = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_MOD-1:0]         eoc,
   input  logic [NUM_INT*NUM_MOD-1:0] mask,
   input  logic [NUM_INT-1:0]         en,
   input  logic [NUM_INT-1:0]         clr,
   output logic [NUM_INT-1:0]         pulse,
   output logic [NUM_INT-1:0]         flag,
   output logic [NUM_INT-1:0]         req
);

   for (genvar k = 0; k < NUM_INT; k++) begin : g_int
      logic p_q;
      logic f_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= 1'b0;
            f_q <= 1'b0;
         end else begin
            p_q <= |(eoc & mask[k*NUM_MOD +: NUM_MOD]);
            if (p_q)         f_q <= 1'b1;
            else if (clr[k]) f_q <= 1'b0;
         end
      end

      assign pulse[k] = p_q;
      assign flag[k]  = f_q;

      AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         pulse[k] |=> flag[k]); // R8
      AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[k] && !pulse[k]) |=> !flag[k]); // R8
   end

   assign req = flag & en;

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
   parameter int NUM_MOD  = 13,
   parameter int SEL_W    = 5,
   parameter int DLY_W    = 8,
   parameter int NUM_TMR  = 4,
   parameter int NUM_PWM  = 12,
   parameter int NUM_INT  = 4,
   parameter int CONV_CYC = 14,
   parameter bit EXT_EDGE = 1'b1,
   localparam int CUR_W   = $clog2(NUM_MOD)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_MOD*SEL_W-1:0]   mod_sel,
   input  logic [NUM_MOD*DLY_W-1:0]   dly_cnt,
   input  logic [NUM_MOD*2-1:0]       dly_div,
   input  logic [NUM_MOD-1:0]         sw_trig,
   input  logic                       ext_st,
   input  logic [NUM_TMR-1:0]         tmr_ovf,
   input  logic [NUM_PWM-1:0]         pwm_evt,
   input  logic [NUM_INT*NUM_MOD-1:0] int_mask,
   input  logic [NUM_INT-1:0]         int_en,
   input  logic [NUM_INT-1:0]         stat_clr,
   output logic [NUM_MOD-1:0]         eoc,
   output logic [NUM_INT-1:0]         int_pulse,
   output logic [NUM_INT-1:0]         int_flag,
   output logic [NUM_INT-1:0]         int_req,
   output logic                       conv_busy,
   output logic [CUR_W-1:0]           conv_mod
);

   initial assert (NUM_INT >= 2) else $error("two loop-back channels required");
   initial assert (NUM_MOD >= 2) else $error("at least two slots required");

   logic               ext_hit;
   logic [NUM_MOD-1:0] hw_trig;
   logic [NUM_MOD-1:0] pend;
   logic [NUM_MOD-1:0] gnt;
   logic               fin;
   logic [CUR_W-1:0]   cur;

   if (EXT_EDGE) begin : g_ext_edge
      logic ext_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ext_q <= 1'b0;
         else        ext_q <= ext_st;
      end
      assign ext_hit = ext_st & ~ext_q;
   end else begin : g_ext_level
      assign ext_hit = ext_st;
   end

   for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
      adc_ts_src_sel #(
         .SEL_W  (SEL_W),
         .NUM_TMR(NUM_TMR),
         .NUM_PWM(NUM_PWM)
      ) u_src (
         .sel    (mod_sel[m*SEL_W +: SEL_W]),
         .ext_hit(ext_hit),
         .scan0  (int_pulse[0]),
         .scan1  (int_pulse[1]),
         .tmr    (tmr_ovf),
         .pwm    (pwm_evt),
         .hw_trig(hw_trig[m])
      );

      adc_ts_chan #(
         .DLY_W(DLY_W),
         .CUR_W(CUR_W),
         .IDX  (m)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .trig   (sw_trig[m] | hw_trig[m]),
         .dly_cnt(dly_cnt[m*DLY_W +: DLY_W]),
         .dly_div(dly_div[m*2 +: 2]),
         .gnt    (gnt[m]),
         .fin    (fin),
         .cur    (cur),
         .pend   (pend[m])
      );
   end

   adc_ts_engine #(
      .NUM_MOD (NUM_MOD),
      .CONV_CYC(CONV_CYC),
      .CUR_W   (CUR_W)
   ) u_engine (
      .clk  (clk),
      .rst_n(rst_n),
      .pend (pend),
      .gnt  (gnt),
      .fin  (fin),
      .cur  (cur),
      .busy (conv_busy),
      .eoc  (eoc)
   );

   adc_ts_irq #(
      .NUM_MOD(NUM_MOD),
      .NUM_INT(NUM_INT)
   ) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .eoc  (eoc),
      .mask (int_mask),
      .en   (int_en),
      .clr  (stat_clr),
      .pulse(int_pulse),
      .flag (int_flag),
      .req  (int_req)
   );

   assign conv_mod = cur;

endmodule

// File: tb/adc_trig_seq_tb_top.sv
`timescale 1ns/1ps
module adc_trig_seq_tb_top;

   localparam int N  = 13;
   localparam int NI = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N*5-1:0]  mod_sel;
   logic [N*8-1:0]  dly_cnt;
   logic [N*2-1:0]  dly_div;
   logic [N-1:0]    sw_trig = '0;
   logic            ext_st = 1'b0;
   logic [3:0]      tmr_ovf = '0;
   logic [11:0]     pwm_evt = '0;
   logic [NI*N-1:0] int_mask;
   logic [NI-1:0]   int_en = '0;
   logic [NI-1:0]   stat_clr = '0;
   logic [N-1:0]    eoc;
   logic [NI-1:0]   int_pulse, int_flag, int_req;
   logic            conv_busy;
   logic [3:0]      conv_mod;

   logic [4:0]   sel_a [N];
   logic [7:0]   dly_a [N];
   logic [1:0]   div_a [N];
   logic [N-1:0] mask_a [NI];

   int cyc = 0;
   int nchk = 0, nerr = 0;
   int eoc_t [N];
   int eoc_n [N];
   int ip_t [NI];
   int ip_n [NI];

   always #2.5 clk = ~clk;

   always_comb begin
      for (int m = 0; m < N; m++) begin
         mod_sel[m*5 +: 5] = sel_a[m];
         dly_cnt[m*8 +: 8] = dly_a[m];
         dly_div[m*2 +: 2] = div_a[m];
      end
      for (int k = 0; k < NI; k++) int_mask[k*N +: N] = mask_a[k];
   end

   adc_trig_seq dut_i (
      .clk(clk), .rst_n(rst_n), .mod_sel(mod_sel), .dly_cnt(dly_cnt), .dly_div(dly_div),
      .sw_trig(sw_trig), .ext_st(ext_st), .tmr_ovf(tmr_ovf), .pwm_evt(pwm_evt),
      .int_mask(int_mask), .int_en(int_en), .stat_clr(stat_clr), .eoc(eoc),
      .int_pulse(int_pulse), .int_flag(int_flag), .int_req(int_req),
      .conv_busy(conv_busy), .conv_mod(conv_mod)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      for (int m = 0; m < N; m++) if (eoc[m]) begin eoc_n[m]++; eoc_t[m] = cyc; end
      for (int k = 0; k < NI; k++) if (int_pulse[k]) begin ip_n[k]++; ip_t[k] = cyc; end
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clr_mon();
      for (int m = 0; m < N; m++) begin eoc_n[m] = 0; eoc_t[m] = -1; end
      for (int k = 0; k < NI; k++) begin ip_n[k] = 0; ip_t[k] = -1; end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fire_sw(input logic [N-1:0] v, output int t0);
      @(negedge clk) sw_trig = v;
      @(negedge clk) sw_trig = '0;
      t0 = cyc;
   endtask

   task automatic fire_code(input int code, output int t0);
      @(negedge clk);
      if (code == 1) ext_st = 1'b1;
      else if (code >= 4 && code <= 7) tmr_ovf[code-4] = 1'b1;
      else if (code >= 8 && code <= 19) pwm_evt[code-8] = 1'b1;
      @(negedge clk);
      ext_st = 1'b0; tmr_ovf = '0; pwm_evt = '0;
      t0 = cyc;
   endtask

   task automatic wait_eoc(input int m, output int t);
      int g = 0;
      while (!eoc[m] && g < 500) begin @(negedge clk); g++; end
      t = cyc;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      int t0, t1, t2, t3, bc, ex, dv;
      for (int m = 0; m < N; m++) begin sel_a[m] = '0; dly_a[m] = '0; div_a[m] = '0; end
      for (int k = 0; k < NI; k++) mask_a[k] = '0;
      clr_mon();
      idle(5);
      rst_n = 1'b1;
      idle(2);

      // reset state
      chk("R5 reset eoc", int'(eoc), 0);
      chk("R5 reset busy", int'(conv_busy), 0);
      chk("R7 reset int_pulse", int'(int_pulse), 0);
      chk("R8 reset int_flag", int'(int_flag), 0);

      // R2 and R5: software start on every slot
      for (int m = 0; m < N; m++) begin
         clr_mon();
         fire_sw(N'(1) << m, t0);
         bc = 0;
         repeat (20) begin
            @(negedge clk);
            if (conv_busy && int'(conv_mod) == m) bc++;
         end
         chk($sformatf("R2 slot %0d eoc latency", m), eoc_t[m] - t0, 15);
         chk($sformatf("R5 slot %0d busy length", m), bc, 14);
         chk($sformatf("R5 slot %0d eoc count", m), eoc_n[m], 1);
      end

      // R3: delay count times prescale divisor on slot 11
      for (int d = 0; d < 4; d++) begin
         foreach (dly_a[i]) ;
         for (int ni = 0; ni < 3; ni++) begin
            dly_a[11] = 8'((ni == 0) ? 1 : (ni == 1 ? 5 : 9));
            div_a[11] = 2'(d);
            dv = (d == 3) ? 16 : (1 << d);
            ex = 15 + int'(dly_a[11]) * dv;
            clr_mon();
            fire_sw(N'(1) << 11, t0);
            idle(ex + 5);
            chk($sformatf("R3 delay n=%0d code=%0d", dly_a[11], d), eoc_t[11] - t0, ex);
         end
      end
      dly_a[11] = '0; div_a[11] = '0;

      // R4 priority, R6 retrigger while pending
      clr_mon();
      fire_sw((N'(1) << 9) | (N'(1) << 3) | (N'(1) << 7), t0);
      idle(18);
      fire_sw(N'(1) << 9, t1);
      idle(40);
      chk("R4 first slot 3", eoc_t[3] - t0, 15);
      chk("R4 second slot 7", eoc_t[7] - t0, 30);
      chk("R4 third slot 9", eoc_t[9] - t0, 45);
      chk("R6 pending retrigger ignored", eoc_n[9], 1);

      // R6 retrigger during delay and during conversion
      clr_mon();
      dly_a[4] = 8'd10;
      fire_sw(N'(1) << 4, t0);
      idle(3);
      fire_sw(N'(1) << 4, t1);
      idle(40);
      chk("R6 delay retrigger count", eoc_n[4], 1);
      chk("R6 delay retrigger timing", eoc_t[4] - t0, 25);
      dly_a[4] = '0;
      clr_mon();
      fire_sw(N'(1) << 2, t0);
      idle(5);
      fire_sw(N'(1) << 2, t1);
      idle(30);
      chk("R6 converting retrigger count", eoc_n[2], 1);

      // R1 source routing on slot 5
      for (int c = 1; c < 20; c++) begin
         if (c == 2 || c == 3) continue;
         sel_a[5] = 5'(c);
         clr_mon();
         fire_code(c, t0);
         idle(20);
         chk($sformatf("R1 code %0d latency", c), eoc_t[5] - t0, 15);
      end
      for (int k = 0; k < 2; k++) begin
         sel_a[5] = 5'(2 + k);
         mask_a[k] = N'(1);
         clr_mon();
         fire_sw(N'(1), t0);
         idle(40);
         chk($sformatf("R1 loop-back code %0d latency", 2 + k), eoc_t[5] - t0, 32);
         mask_a[k] = '0;
      end
      sel_a[5] = 5'd4;
      clr_mon();
      for (int c = 1; c < 20; c++) if (c != 4 && c != 2 && c != 3) fire_code(c, t0);
      idle(20);
      chk("R1 unselected sources ignored", eoc_n[5], 0);
      foreach (sel_a[i]) ;
      for (int s = 0; s < 2; s++) begin
         sel_a[5] = (s == 0) ? 5'd0 : 5'd25;
         clr_mon();
         for (int c = 1; c < 20; c++) if (c != 2 && c != 3) fire_code(c, t0);
         idle(20);
         chk($sformatf("R1 code %0d selects nothing", sel_a[5]), eoc_n[5], 0);
      end

      // R10: held pin triggers once
      sel_a[5] = 5'd1;
      clr_mon();
      @(negedge clk) ext_st = 1'b1;
      idle(50);
      @(negedge clk) ext_st = 1'b0;
      idle(5);
      chk("R10 held pin single start", eoc_n[5], 1);
      sel_a[5] = '0;

      // R7 and R8: masks, flags, enable, clear
      @(negedge clk) stat_clr = '1;
      @(negedge clk) stat_clr = '0;
      chk("R8 flags cleared", int'(int_flag), 0);
      mask_a[3] = N'(1) << 6;
      mask_a[1] = N'(1) << 6;
      int_en = 4'b1000;
      clr_mon();
      fire_sw(N'(1) << 7, t0);
      idle(25);
      chk("R7 unmasked slot no pulse", ip_n[0] + ip_n[1] + ip_n[2] + ip_n[3], 0);
      clr_mon();
      fire_sw(N'(1) << 6, t0);
      idle(25);
      chk("R7 pulse timing ch3", ip_t[3] - t0, 16);
      chk("R7 pulse pattern", ip_n[0] + 2 * ip_n[1] + 4 * ip_n[2] + 8 * ip_n[3], 10);
      chk("R8 flags set", int'(int_flag), 4'b1010);
      chk("R8 request gated", int'(int_req), 4'b1000);
      @(negedge clk) stat_clr = 4'b1000;
      @(negedge clk) stat_clr = '0;
      chk("R8 write-1 clear", int'(int_flag), 4'b0010);
      chk("R8 request dropped", int'(int_req), 0);
      mask_a[3] = '0; mask_a[1] = '0; int_en = '0;

      // R9: self-sustained scan on slot 8
      sel_a[8] = 5'd2;
      mask_a[0] = N'(1) << 8;
      clr_mon();
      fire_sw(N'(1) << 8, t0);
      wait_eoc(8, t1);
      wait_eoc(8, t2);
      wait_eoc(8, t3);
      sel_a[8] = '0;
      chk("R9 first conversion", t1 - t0, 15);
      chk("R9 scan period a", t2 - t1, 17);
      chk("R9 scan period b", t3 - t2, 17);
      idle(60);
      chk("R9 scan stops", eoc_n[8], 3);
      mask_a[0] = '0;

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule